// File: doc/BRIEF.md
# Calibrated Channel Summing Unit

This block turns raw digitiser samples into tile energy sums for a low-latency trigger path. Each sample clock it takes one 14-bit unsigned sample from every channel of a tile and subtracts a per-channel pedestal. It scales the difference by a per-channel gain factor and adds the corrected values of all channels of the tile. Two tiles (lanes) are handled side by side with no interaction. Each lane sum loses its two least significant bits and is clamped into a 16-bit word. The word is then wrapped in an 18-bit frame with a start and a stop bit, ready for a 16-bit serializer.

Pedestals and gains are first written into a shadow bank one register at a time. A single commit pulse then copies the whole shadow bank into the working bank in one clock. Each sample keeps the settings that were in the working bank when it entered the pipeline. A sample therefore never mixes old and new calibration, and the sums do not glitch when calibration changes.

Top module: `tile_sum_unit`

## Requirements
- R1: `sum_valid` rises exactly three clock edges after the edge that captures `smp_valid` high, and each result appears with that same fixed latency of 3 clocks.
- R2: For each channel, difference = sample − pedestal. A negative difference is clamped to zero before scaling.
- R3: Gain is unsigned fixed point with 1 integer bit and 11 fractional bits (2048 = unity). The corrected value is (difference × gain + 1024) >> 11, so halves round up.
- R4: A lane word is the sum of its 16 corrected channel values shifted right by 2, with the discarded bits truncated.
- R5: When the shifted sum exceeds 65535, the word saturates at 16'hFFFF.
- R6: The two lanes are computed independently. Lane l reads sample bits starting at (l·16+c)·14 and drives `sum_word[l*16 +: 16]`.
- R7: A configuration write (`cfg_kind` 0 = pedestal, 1 = gain; data in `cfg_wdata`, target in `cfg_lane`/`cfg_ch`) changes only the shadow bank. Outputs are unaffected until `cfg_commit` is pulsed. A sample presented in the cycle of the commit uses the old set, and the next sample uses the new set.
- R8: After reset, every pedestal is 0 and every gain is 2048. `sum_valid` is 0, and words and frames are zero.
- R9: The frame of each lane is 18 bits: bit 17 is a start bit of 1, bits 16..1 hold the word, and bit 0 is a stop bit of 0. When `sum_valid` is low the frame is all zeros.
- R10: While `sum_valid` is low, every `sum_word` lane reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Sample set present this clock |
| smp_data | input | 448 | 32 samples of 14 bits, lane-major then channel |
| cfg_we | input | 1 | Write strobe for the shadow bank |
| cfg_kind | input | 1 | 0 = pedestal, 1 = gain |
| cfg_lane | input | 1 | Target lane |
| cfg_ch | input | 4 | Target channel |
| cfg_wdata | input | 14 | Value written (gain uses the low 12 bits) |
| cfg_commit | input | 1 | Copy the shadow bank into the working bank |
| sum_valid | output | 1 | Output words and frames are valid |
| sum_word | output | 32 | One 16-bit truncated, saturated sum per lane |
| sum_frame | output | 36 | One 18-bit serializer frame per lane |

## Verification
The assertions assume that `smp_valid`, `cfg_commit` and `rst` are driven to known levels from the first clock edge. The latency property counts cycles since reset, so it relies on `smp_valid` being low during reset. The stimulus drives every input at the falling edge, holds `smp_valid` and `cfg_commit` low throughout reset, and never issues a shadow write in the same cycle as a commit.

// File: rtl/tsu_pkg.sv
package tsu_pkg;
  typedef enum logic {
    CFG_PEDESTAL = 1'b0,
    CFG_GAIN     = 1'b1
  } cfg_kind_e;
endpackage

// File: rtl/tsu_cfg_bank.sv
module tsu_cfg_bank
  import tsu_pkg::*;
#(
  parameter int NLANE = 2,
  parameter int NCH   = 16,
  parameter int SW    = 14,
  parameter int GW    = 12,
  parameter int FRAC  = 11,
  parameter int LW    = 1,
  parameter int CHW   = 4,
  parameter int DW    = 14
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   cfg_we,
  input  cfg_kind_e              cfg_kind,
  input  logic [LW-1:0]          cfg_lane,
  input  logic [CHW-1:0]         cfg_ch,
  input  logic [DW-1:0]          cfg_wdata,
  input  logic                   cfg_commit,
  output logic [NLANE*NCH*SW-1:0] act_base,
  output logic [NLANE*NCH*GW-1:0] act_gain
);
  localparam logic [GW-1:0] UNITY = GW'(1) << FRAC;

  for (genvar l = 0; l < NLANE; l++) begin : g_lane
    for (genvar c = 0; c < NCH; c++) begin : g_ch
      localparam int IDX = l * NCH + c;
      logic [SW-1:0] shd_base;
      logic [GW-1:0] shd_gain;
      logic          hit;
      assign hit = cfg_we && (int'(cfg_lane) == l) && (int'(cfg_ch) == c);

      always_ff @(posedge clk) begin
        if (rst) begin
          shd_base <= '0;
          shd_gain <= UNITY;
        end else if (hit) begin
          if (cfg_kind == CFG_PEDESTAL) shd_base <= cfg_wdata[SW-1:0];
          else                          shd_gain <= cfg_wdata[GW-1:0];
        end
      end

      always_ff @(posedge clk) begin
        if (rst) begin
          act_base[IDX*SW +: SW] <= '0;
          act_gain[IDX*GW +: GW] <= UNITY;
        end else if (cfg_commit) begin
          act_base[IDX*SW +: SW] <= shd_base;
          act_gain[IDX*GW +: GW] <= shd_gain;
        end
      end
    end
  end
endmodule

// File: rtl/tsu_chan_corr.sv
module tsu_chan_corr #(
  parameter int SW   = 14,
  parameter int GW   = 12,
  parameter int FRAC = 11,
  parameter int CW   = SW + GW - FRAC
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [SW-1:0] smp,
  input  logic [SW-1:0] base,
  input  logic [GW-1:0] gain,
  output logic [CW-1:0] corr
);
  localparam int PW = SW + GW + 1;

  function automatic logic [SW-1:0] clamp_sub(logic [SW-1:0] a, logic [SW-1:0] b);
    logic [SW:0] d;
    d = {1'b0, a} - {1'b0, b};
    return d[SW] ? '0 : d[SW-1:0];
  endfunction

  function automatic logic [CW-1:0] scale_round(logic [SW-1:0] d, logic [GW-1:0] g);
    logic [PW-1:0] p;
    p = PW'(d) * PW'(g) + (PW'(1) << (FRAC - 1));
    return CW'(p >> FRAC);
  endfunction

  logic [SW-1:0] diff_q;
  logic [GW-1:0] gain_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      diff_q <= '0;
      gain_q <= '0;
      corr   <= '0;
    end else begin
      diff_q <= clamp_sub(smp, base);
      gain_q <= gain;
      corr   <= scale_round(diff_q, gain_q);
    end
  end
endmodule

// File: rtl/tsu_lane_sum.sv
module tsu_lane_sum #(
  parameter int NCH  = 16,
  parameter int CW   = 15,
  parameter int DROP = 2,
  parameter int OW   = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              out_valid,
  input  logic [NCH*CW-1:0] corr,
  output logic [OW-1:0]     word,
  output logic [OW+1:0]     frame
);
  localparam int SUMW = CW + $clog2(NCH);

  function automatic logic [OW-1:0] trunc_sat(logic [SUMW-1:0] s);
    logic [SUMW-1:0] t;
    t = s >> DROP;
    return (t > SUMW'({OW{1'b1}})) ? {OW{1'b1}} : t[OW-1:0];
  endfunction

  logic [SUMW-1:0] total;
  always_comb begin
    total = '0;
    for (int c = 0; c < NCH; c++) total = total + SUMW'(corr[c*CW +: CW]);
  end

  always_ff @(posedge clk) begin
    if (rst)           word <= '0;
    else if (in_valid) word <= trunc_sat(total);
    else               word <= '0;
  end

  assign frame = out_valid ? {1'b1, word, 1'b0} : '0;
endmodule

// File: rtl/tile_sum_unit.sv
module tile_sum_unit
  import tsu_pkg::*;
#(
  parameter int NLANE = 2,
  parameter int NCH   = 16,
  parameter int SW    = 14,
  parameter int GW    = 12,
  parameter int FRAC  = 11,
  parameter int DROP  = 2,
  parameter int OW    = 16,
  localparam int LW   = (NLANE > 1) ? $clog2(NLANE) : 1,
  localparam int CHW  = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int DW   = (SW > GW) ? SW : GW,
  localparam int CW   = SW + GW - FRAC,
  localparam int FW   = OW + 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    smp_valid,
  input  logic [NLANE*NCH*SW-1:0] smp_data,
  input  logic                    cfg_we,
  input  logic                    cfg_kind,
  input  logic [LW-1:0]           cfg_lane,
  input  logic [CHW-1:0]          cfg_ch,
  input  logic [DW-1:0]           cfg_wdata,
  input  logic                    cfg_commit,
  output logic                    sum_valid,
  output logic [NLANE*OW-1:0]     sum_word,
  output logic [NLANE*FW-1:0]     sum_frame
);
  logic [NLANE*NCH*SW-1:0] act_base;
  logic [NLANE*NCH*GW-1:0] act_gain;
  logic [NLANE*NCH*CW-1:0] corr_all;
  logic vld_s1, vld_s2;

  tsu_cfg_bank #(
    .NLANE(NLANE), .NCH(NCH), .SW(SW), .GW(GW), .FRAC(FRAC),
    .LW(LW), .CHW(CHW), .DW(DW)
  ) u_bank (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_kind(cfg_kind_e'(cfg_kind)),
    .cfg_lane(cfg_lane), .cfg_ch(cfg_ch), .cfg_wdata(cfg_wdata),
    .cfg_commit(cfg_commit), .act_base(act_base), .act_gain(act_gain)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_s1    <= 1'b0;
      vld_s2    <= 1'b0;
      sum_valid <= 1'b0;
    end else begin
      vld_s1    <= smp_valid;
      vld_s2    <= vld_s1;
      sum_valid <= vld_s2;
    end
  end

  for (genvar i = 0; i < NLANE * NCH; i++) begin : g_corr
    tsu_chan_corr #(.SW(SW), .GW(GW), .FRAC(FRAC), .CW(CW)) u_corr (
      .clk(clk), .rst(rst),
      .smp(smp_data[i*SW +: SW]),
      .base(act_base[i*SW +: SW]),
      .gain(act_gain[i*GW +: GW]),
      .corr(corr_all[i*CW +: CW])
    );
  end

  for (genvar l = 0; l < NLANE; l++) begin : g_lane
    tsu_lane_sum #(.NCH(NCH), .CW(CW), .DROP(DROP), .OW(OW)) u_sum (
      .clk(clk), .rst(rst), .in_valid(vld_s2), .out_valid(sum_valid),
      .corr(corr_all[l*NCH*CW +: NCH*CW]),
      .word(sum_word[l*OW +: OW]),
      .frame(sum_frame[l*FW +: FW])
    );
  end
endmodule

// File: rtl/tsu_checker.sv
module tsu_checker #(
  parameter int NLANE = 2,
  parameter int OW    = 16,
  parameter int BW    = 448,
  parameter int GBW   = 384
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  in_valid,
  input logic                  out_valid,
  input logic [NLANE*OW-1:0]   word,
  input logic [NLANE*(OW+2)-1:0] frame,
  input logic                  commit,
  input logic [BW-1:0]         act_base,
  input logic [GBW-1:0]        act_gain
);
  logic [1:0] since_rst;
  logic       d1, d2, d3;
  always_ff @(posedge clk) begin
    if (rst) begin
      since_rst <= '0;
      d1 <= 1'b0; d2 <= 1'b0; d3 <= 1'b0;
    end else begin
      if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
      d1 <= in_valid; d2 <= d1; d3 <= d2;
    end
  end

  // R1: output valid mirrors input valid three edges later
  a_r1_valid_latency: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 2'd3) |-> (out_valid == d3));

  // R7: working bank moves only on a commit
  a_r7_bank_hold: assert property (@(posedge clk) disable iff (rst)
    !commit |=> ($stable(act_base) && $stable(act_gain)));

  // R10: idle words are zero
  a_r10_idle_word: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> (word == '0));

  for (genvar l = 0; l < NLANE; l++) begin : g_fr
    // R9: idle frame is all zeros
    a_r9_idle_frame: assert property (@(posedge clk) disable iff (rst)
      !out_valid |-> (frame[l*(OW+2) +: OW+2] == '0));
    // R9: start and stop bits around the lane word
    a_r9_frame_marks: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> (frame[l*(OW+2)+OW+1] && !frame[l*(OW+2)]
                     && frame[l*(OW+2)+1 +: OW] == word[l*OW +: OW]));
  end
endmodule

bind tile_sum_unit tsu_checker #(
  .NLANE(NLANE), .OW(OW), .BW(NLANE*NCH*SW), .GBW(NLANE*NCH*GW)
) u_chk (
  .clk(clk), .rst(rst), .in_valid(smp_valid), .out_valid(sum_valid),
  .word(sum_word), .frame(sum_frame), .commit(cfg_commit),
  .act_base(act_base), .act_gain(act_gain)
);

// File: tb/tb_tile_sum_unit.sv
module tb_tile_sum_unit;
  localparam int NL = 2, NC = 16, SW = 14;
  logic clk = 1'b0, rst = 1'b1;
  logic smp_valid = 1'b0;
  logic [NL*NC*SW-1:0] smp_data = '0;
  logic cfg_we = 1'b0, cfg_kind = 1'b0, cfg_commit = 1'b0;
  logic [0:0] cfg_lane = '0;
  logic [3:0] cfg_ch = '0;
  logic [13:0] cfg_wdata = '0;
  logic sum_valid;
  logic [NL*16-1:0] sum_word;
  logic [NL*18-1:0] sum_frame;

  tile_sum_unit dut (.*);

  always #10 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;
  int sm[NL][NC];
  int pb[NL][NC], pg[NL][NC];   // working settings model
  int sb[NL][NC], sg[NL][NC];   // shadow settings model

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int model(int l);
    int s = 0;
    for (int c = 0; c < NC; c++) begin
      int d = sm[l][c] - pb[l][c];
      if (d > 0) s += (d * pg[l][c] + 1024) / 2048;
    end
    s = s / 4;
    return (s > 65535) ? 65535 : s;
  endfunction

  task automatic load();
    for (int l = 0; l < NL; l++)
      for (int c = 0; c < NC; c++)
        smp_data[(l*NC+c)*SW +: SW] = 14'(sm[l][c]);
  endtask

  task automatic cfg_write(int l, int kind, int c, int v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_kind = 1'(kind); cfg_lane = 1'(l); cfg_ch = 4'(c); cfg_wdata = 14'(v);
    if (kind == 0) sb[l][c] = v; else sg[l][c] = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic commit();
    @(negedge clk);
    cfg_commit = 1'b1;
    @(negedge clk);
    cfg_commit = 1'b0;
    pb = sb; pg = sg;
  endtask

  task automatic run_check(string req);
    int e0, e1;
    @(negedge clk);
    load(); smp_valid = 1'b1;
    e0 = model(0); e1 = model(1);
    @(negedge clk); smp_valid = 1'b0;
    @(negedge clk);
    check({req, " valid early"}, sum_valid, 0);
    @(negedge clk);
    check({req, " valid"}, sum_valid, 1);
    check({req, " lane0"}, sum_word[15:0], e0);
    check({req, " lane1"}, sum_word[31:16], e1);
  endtask

  task automatic t_reset();
    check("R8 valid", sum_valid, 0);
    check("R8 word", int'(sum_word), 0);
    check("R9 frame idle", int'(sum_frame[31:0]) | int'(sum_frame[35:32]), 0);
  endtask

  task automatic t_unity();
    for (int l = 0; l < NL; l++)
      for (int c = 0; c < NC; c++) sm[l][c] = 100 * c + 7 * l + 3;
    run_check("R8 R4 R1 unity");
    @(negedge clk);
    check("R10 idle word", int'(sum_word), 0);
  endtask

  task automatic t_pedestal();
    for (int c = 0; c < NC; c++) cfg_write(0, 0, c, 400);
    for (int c = 0; c < NC; c++) sm[0][c] = 390 + 2 * c;   // some below pedestal
    for (int c = 0; c < NC; c++) sm[1][c] = 1000;
    run_check("R7 shadow not visible");
    commit();
    run_check("R2 pedestal clamp");
  endtask

  task automatic t_gain();
    for (int c = 0; c < NC; c++) begin
      cfg_write(1, 1, c, (c % 2) ? 1024 : 3001 + c);
      cfg_write(1, 0, c, (c % 2) ? 7 : 0);
    end
    commit();
    for (int c = 0; c < NC; c++) sm[1][c] = (c % 2) ? 8 : 333 * c + 5; // d=1,g=1024 -> rounds up to 1
    run_check("R3 gain rounding");
  endtask

  task automatic t_saturate();
    for (int c = 0; c < NC; c++) begin
      cfg_write(0, 1, c, 4095);
      cfg_write(0, 0, c, 0);
    end
    commit();
    for (int c = 0; c < NC; c++) begin sm[0][c] = 16383; sm[1][c] = 12; end
    run_check("R5 R6 saturate");
    check("R5 ceiling", int'(sum_word[15:0]), 65535);
  endtask

  task automatic t_frame();
    int e;
    @(negedge clk);
    for (int c = 0; c < NC; c++) sm[0][c] = 50 + c;
    load(); smp_valid = 1'b1; e = model(0);
    @(negedge clk); smp_valid = 1'b0;
    @(negedge clk); @(negedge clk);
    check("R9 frame lane0", int'(sum_frame[17:0]), (1 << 17) | (e << 1));
    check("R9 start lane1", int'(sum_frame[35]), 1);
    check("R9 stop lane1", int'(sum_frame[18]), 0);
  endtask

  task automatic t_boundary();
    int ea, eb;
    for (int c = 0; c < NC; c++) cfg_write(1, 0, c, 200);
    for (int c = 0; c < NC; c++) sm[1][c] = 500 + c;
    @(negedge clk);
    load(); smp_valid = 1'b1; cfg_commit = 1'b1;
    ea = model(1);
    pb = sb; pg = sg;
    eb = model(1);
    @(negedge clk);
    cfg_commit = 1'b0;
    @(negedge clk); smp_valid = 1'b0;
    @(negedge clk);
    check("R7 commit-cycle sample old set", int'(sum_word[31:16]), ea);
    @(negedge clk);
    check("R7 next sample new set", int'(sum_word[31:16]), eb);
    check("R1 back-to-back valid", sum_valid, 1);
  endtask

  initial begin
    for (int l = 0; l < NL; l++)
      for (int c = 0; c < NC; c++) begin
        pb[l][c] = 0; pg[l][c] = 2048; sb[l][c] = 0; sg[l][c] = 2048; sm[l][c] = 0;
      end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_unity();
    t_pedestal();
    t_gain();
    t_saturate();
    t_frame();
    t_boundary();
    repeat (2) @(negedge clk);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule